// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a data addressing request of a 16-bit segmented processor into an operand offset and a 20-bit physical address. The decoder supplies an addressing-mode code, the pointer register selects, the current contents of the four pointer registers (BX, BP, SI, DI), a displacement with a width flag, the four segment register values and an optional segment override. One clock after a request is presented with `inValid` high, the block presents the computed offset, the physical address and the code of the segment it used, and raises `outValid` for that cycle.

The offset is the sum of the terms that the mode selects. These are a single pointer, a base plus an index, and an optional displacement. The sum is taken modulo 2^16. The physical address is the chosen segment value shifted left by four bits, plus that offset, taken modulo 2^20. The segment is chosen from the registers that take part in the address. An explicit override replaces that choice. Immediate and register operands carry no memory address, and the block flags them as such.

Top module: `ea_gen`

## Requirements
- R1: While `rstN` is low and after its release, until the first request, `outValid`, `outNoAddr`, `outOffset`, `outPhys` and `outSeg` are all zero.
- R2: A request taken with `inValid` high shows its result on the outputs one clock later, with `outValid` high for exactly that cycle. While `inValid` is low, `outValid` is low and the result outputs keep their last values.
- R3: `outPhys` equals (segment value × 16 + `outOffset`) modulo 2^20.
- R4: Mode codes 0 (immediate), 1 (register) and 7 (unused) set `outNoAddr` to 1 and give zero on `outOffset`, `outPhys` and `outSeg`.
- R5: Mode 2 (direct) takes the whole 16-bit `disp` as the offset, whatever `dispWide` holds, and uses DS by default.
- R6: Mode 3 (pointer indirect) takes the offset from the register that `ptrSel` names (0 BX, 1 BP, 2 SI, 3 DI). The default segment is DS for BX and SI, SS for BP and ES for DI.
- R7: Mode 4 (pointer plus displacement) adds the displacement to the register that `ptrSel` names. It uses the same default segments as R6.
- R8: Mode 5 (base plus index) adds the base (`baseSel` 0 BX, 1 BP) to the index (`idxSel` 0 SI, 1 DI). The default segment is SS when the base is BP and DS otherwise.
- R9: Mode 6 (base plus index plus displacement) adds the displacement to the sum of R8 and uses the same default segment.
- R10: When `dispWide` is 0, the displacement is bit 7..0 of `disp`, sign-extended to 16 bits. When it is 1, the displacement is all 16 bits.
- R11: The offset sum wraps modulo 2^16 before the segment term is added.
- R12: With `ovrEn` high, `ovrSeg` picks the segment in every address mode (0 ES, 1 CS, 2 SS, 3 DS). `outSeg` reports the segment used, in the same coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe; loads the result register |
| mode | input | 3 | Addressing-mode code |
| ptrSel | input | 2 | Single pointer select (0 BX, 1 BP, 2 SI, 3 DI) |
| baseSel | input | 1 | Base select (0 BX, 1 BP) |
| idxSel | input | 1 | Index select (0 SI, 1 DI) |
| regBx | input | 16 | BX contents |
| regBp | input | 16 | BP contents |
| regSi | input | 16 | SI contents |
| regDi | input | 16 | DI contents |
| disp | input | 16 | Displacement field |
| dispWide | input | 1 | 1: 16-bit displacement, 0: sign-extended byte |
| segEs | input | 16 | ES value |
| segCs | input | 16 | CS value |
| segSs | input | 16 | SS value |
| segDs | input | 16 | DS value |
| ovrEn | input | 1 | Segment override enable |
| ovrSeg | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| outValid | output | 1 | Result valid, one cycle after the request |
| outNoAddr | output | 1 | Operand has no memory address |
| outOffset | output | 16 | Operand offset |
| outPhys | output | 20 | Physical address |
| outSeg | output | 2 | Segment code used |

## Verification
The bench builds the block with its default widths: a 16-bit offset and a 4-bit segment shift. Every carry therefore sits at the real 2^16 and 2^20 boundaries. Pointer and segment values near the top of their range make both wraps reachable in a single request. The same values expose sign extension of byte displacements around 0x80 and 0xFF, and every default-segment and override combination of the seven addressing modes.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int NUM_PTR = 4;
  localparam int NUM_SEG = 4;

  typedef enum logic [2:0] {
    MODE_IMM    = 3'd0,
    MODE_REG    = 3'd1,
    MODE_DIRECT = 3'd2,
    MODE_PTR    = 3'd3,
    MODE_PTRREL = 3'd4,
    MODE_BASEIX = 3'd5,
    MODE_BIXREL = 3'd6,
    MODE_UNUSED = 3'd7
  } modeT;

  // Pointer index order used by the datapath operand vector.
  localparam int PTR_BX = 0;
  localparam int PTR_BP = 1;
  localparam int PTR_SI = 2;
  localparam int PTR_DI = 3;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } segT;

  // Strobes from control to datapath.
  typedef struct packed {
    logic               load;
    logic               noAddr;
    logic [NUM_PTR-1:0] ptrMask;
    logic               addDisp;
    logic               dispSext;
    segT                seg;
  } eaStrobesT;
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] mode,
  input  logic [1:0] ptrSel,
  input  logic       baseSel,
  input  logic       idxSel,
  input  logic       dispWide,
  input  logic       ovrEn,
  input  logic [1:0] ovrSeg,
  output eaStrobesT  strb,
  output logic       outValid
);

  function automatic segT ptrDefault(input logic [1:0] sel);
    case (sel)
      2'd1:    return SEG_SS;
      2'd3:    return SEG_ES;
      default: return SEG_DS;
    endcase
  endfunction

  logic [1:0] baseIdx;
  logic [1:0] indexIdx;
  segT        defSeg;

  assign baseIdx  = baseSel ? 2'(PTR_BP) : 2'(PTR_BX);
  assign indexIdx = idxSel  ? 2'(PTR_DI) : 2'(PTR_SI);

  always_comb begin
    strb          = '0;
    strb.load     = inValid;
    strb.dispSext = ~dispWide;
    defSeg        = SEG_DS;
    unique case (modeT'(mode))
      MODE_DIRECT: begin
        strb.addDisp  = 1'b1;
        strb.dispSext = 1'b0;
        defSeg        = SEG_DS;
      end
      MODE_PTR: begin
        strb.ptrMask[ptrSel] = 1'b1;
        defSeg               = ptrDefault(ptrSel);
      end
      MODE_PTRREL: begin
        strb.ptrMask[ptrSel] = 1'b1;
        strb.addDisp         = 1'b1;
        defSeg               = ptrDefault(ptrSel);
      end
      MODE_BASEIX, MODE_BIXREL: begin
        strb.ptrMask[baseIdx]  = 1'b1;
        strb.ptrMask[indexIdx] = 1'b1;
        strb.addDisp           = (modeT'(mode) == MODE_BIXREL);
        defSeg                 = baseSel ? SEG_SS : SEG_DS;
      end
      default: begin
        strb.noAddr = 1'b1;
        defSeg      = SEG_ES;
      end
    endcase
    if (strb.noAddr)   strb.seg = SEG_ES;
    else if (ovrEn)    strb.seg = segT'(ovrSeg);
    else               strb.seg = defSeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/ea_datapath.sv
module ea_datapath
  import ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DISP_NARROW = 8,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  eaStrobesT                     strb,
  input  logic [NUM_PTR-1:0][OFS_W-1:0] ptrRegs,
  input  logic [OFS_W-1:0]              disp,
  input  logic [NUM_SEG-1:0][OFS_W-1:0] segRegs,
  output logic                          outNoAddr,
  output logic [OFS_W-1:0]              outOffset,
  output logic [PHYS_W-1:0]             outPhys,
  output logic [1:0]                    outSeg
);

  logic [OFS_W-1:0]  dispExt;
  logic [OFS_W-1:0]  ptrTerm [NUM_PTR];
  logic [OFS_W-1:0]  offsetSum;
  logic [PHYS_W-1:0] segBase;
  logic [PHYS_W-1:0] physSum;

  assign dispExt = strb.dispSext
                 ? {{(OFS_W-DISP_NARROW){disp[DISP_NARROW-1]}}, disp[DISP_NARROW-1:0]}
                 : disp;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_term
    assign ptrTerm[g] = strb.ptrMask[g] ? ptrRegs[g] : '0;
  end

  always_comb begin
    offsetSum = strb.addDisp ? dispExt : '0;
    for (int i = 0; i < NUM_PTR; i++) offsetSum = offsetSum + ptrTerm[i];
  end

  assign segBase = {segRegs[strb.seg], {SEG_SHIFT{1'b0}}};
  assign physSum = segBase + PHYS_W'(offsetSum);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outNoAddr <= 1'b0;
      outOffset <= '0;
      outPhys   <= '0;
      outSeg    <= '0;
    end else if (strb.load) begin
      outNoAddr <= strb.noAddr;
      outOffset <= strb.noAddr ? '0 : offsetSum;
      outPhys   <= strb.noAddr ? '0 : physSum;
      outSeg    <= strb.noAddr ? 2'd0 : strb.seg;
    end
  end

  // R4
  no_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outNoAddr |-> (outPhys == '0 && outOffset == '0 && outSeg == 2'd0));

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        mode,
  input  logic [1:0]        ptrSel,
  input  logic              baseSel,
  input  logic              idxSel,
  input  logic [OFS_W-1:0]  regBx,
  input  logic [OFS_W-1:0]  regBp,
  input  logic [OFS_W-1:0]  regSi,
  input  logic [OFS_W-1:0]  regDi,
  input  logic [OFS_W-1:0]  disp,
  input  logic              dispWide,
  input  logic [OFS_W-1:0]  segEs,
  input  logic [OFS_W-1:0]  segCs,
  input  logic [OFS_W-1:0]  segSs,
  input  logic [OFS_W-1:0]  segDs,
  input  logic              ovrEn,
  input  logic [1:0]        ovrSeg,
  output logic              outValid,
  output logic              outNoAddr,
  output logic [OFS_W-1:0]  outOffset,
  output logic [PHYS_W-1:0] outPhys,
  output logic [1:0]        outSeg
);

  eaStrobesT                     strb;
  logic [NUM_PTR-1:0][OFS_W-1:0] ptrRegs;
  logic [NUM_SEG-1:0][OFS_W-1:0] segRegs;

  assign ptrRegs = {regDi, regSi, regBp, regBx};
  assign segRegs = {segDs, segSs, segCs, segEs};

  ea_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .ptrSel(ptrSel), .baseSel(baseSel), .idxSel(idxSel),
    .dispWide(dispWide), .ovrEn(ovrEn), .ovrSeg(ovrSeg),
    .strb(strb), .outValid(outValid)
  );

  ea_datapath #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .ptrRegs(ptrRegs), .disp(disp),
    .segRegs(segRegs), .outNoAddr(outNoAddr), .outOffset(outOffset),
    .outPhys(outPhys), .outSeg(outSeg)
  );

  // R12
  override_seg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ovrEn && mode >= 3'd2 && mode <= 3'd6) |=> outSeg == $past(ovrSeg));
  // R2
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outOffset) && $stable(outPhys) && $stable(outSeg)));

endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic        baseSel = 1'b0, idxSel = 1'b0;
  logic [15:0] regBx = 16'h1000, regBp = 16'h2000, regSi = 16'h0030, regDi = 16'h0400;
  logic [15:0] disp = '0;
  logic        dispWide = 1'b0;
  logic [15:0] segEs = 16'h1000, segCs = 16'h2000, segSs = 16'h3000, segDs = 16'h4000;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic        outValid, outNoAddr;
  logic [15:0] outOffset;
  logic [19:0] outPhys;
  logic [1:0]  outSeg;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ea_gen i_ea_gen (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode), .ptrSel(ptrSel),
    .baseSel(baseSel), .idxSel(idxSel), .regBx(regBx), .regBp(regBp),
    .regSi(regSi), .regDi(regDi), .disp(disp), .dispWide(dispWide),
    .segEs(segEs), .segCs(segCs), .segSs(segSs), .segDs(segDs),
    .ovrEn(ovrEn), .ovrSeg(ovrSeg), .outValid(outValid), .outNoAddr(outNoAddr),
    .outOffset(outOffset), .outPhys(outPhys), .outSeg(outSeg)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  mode;
    logic [1:0]  ptr;
    logic        base;
    logic        idx;
    logic [15:0] disp;
    logic        wide;
    logic        ovr;
    logic [1:0]  ovrSeg;
    logic        noAddr;
    logic [15:0] ofs;
    logic [19:0] phys;
    logic [1:0]  seg;
  } vecT;

  // Registers: BX 1000 BP 2000 SI 0030 DI 0400; segments ES 1000 CS 2000 SS 3000 DS 4000
  localparam int NV = 20;
  localparam vecT VECS [NV] = '{
    '{8'd4,  3'd0, 2'd0, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 2'd0, 1'b1, 16'h0000, 20'h00000, 2'd0}, // R4 immediate
    '{8'd4,  3'd1, 2'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd2, 1'b1, 16'h0000, 20'h00000, 2'd0}, // R4 register
    '{8'd5,  3'd2, 2'd0, 1'b0, 1'b0, 16'h5000, 1'b1, 1'b0, 2'd0, 1'b0, 16'h5000, 20'h45000, 2'd3}, // R5 direct
    '{8'd5,  3'd2, 2'd0, 1'b0, 1'b0, 16'h0080, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0080, 20'h40080, 2'd3}, // R5 flag ignored
    '{8'd6,  3'd3, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1000, 20'h41000, 2'd3}, // R6 BX
    '{8'd6,  3'd3, 2'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h2000, 20'h32000, 2'd2}, // R6 BP
    '{8'd6,  3'd3, 2'd2, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0030, 20'h40030, 2'd3}, // R6 SI
    '{8'd6,  3'd3, 2'd3, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0400, 20'h10400, 2'd0}, // R6 DI
    '{8'd7,  3'd4, 2'd0, 1'b0, 1'b0, 16'h0050, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1050, 20'h41050, 2'd3}, // R7 BX+50
    '{8'd10, 3'd4, 2'd2, 1'b0, 1'b0, 16'h00F0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0020, 20'h40020, 2'd3}, // R10 SI-16
    '{8'd7,  3'd4, 2'd3, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0, 2'd0, 1'b0, 16'h1634, 20'h11634, 2'd0}, // R7 DI+1234
    '{8'd10, 3'd4, 2'd1, 1'b0, 1'b0, 16'hAA80, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1F80, 20'h31F80, 2'd2}, // R10 BP-128
    '{8'd8,  3'd5, 2'd0, 1'b0, 1'b0, 16'h7777, 1'b1, 1'b0, 2'd0, 1'b0, 16'h1030, 20'h41030, 2'd3}, // R8 BX+SI
    '{8'd8,  3'd5, 2'd0, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h2400, 20'h32400, 2'd2}, // R8 BP+DI
    '{8'd8,  3'd5, 2'd0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1400, 20'h41400, 2'd3}, // R8 BX+DI
    '{8'd9,  3'd6, 2'd0, 1'b0, 1'b0, 16'h0050, 1'b0, 1'b0, 2'd0, 1'b0, 16'h1080, 20'h41080, 2'd3}, // R9 BX+SI+50
    '{8'd9,  3'd6, 2'd0, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 2'd0, 1'b0, 16'h202F, 20'h3202F, 2'd2}, // R9 BP+SI-1
    '{8'd12, 3'd3, 2'd1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 2'd3, 1'b0, 16'h2000, 20'h42000, 2'd3}, // R12 BP->DS
    '{8'd12, 3'd2, 2'd0, 1'b0, 1'b0, 16'h0010, 1'b1, 1'b1, 2'd0, 1'b0, 16'h0010, 20'h10010, 2'd0}, // R12 direct->ES
    '{8'd12, 3'd6, 2'd0, 1'b0, 1'b1, 16'h0005, 1'b0, 1'b1, 2'd1, 1'b0, 16'h1405, 20'h21405, 2'd1}  // R12 ->CS
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input vecT v);
    @(negedge clk);
    inValid = 1'b1; mode = v.mode; ptrSel = v.ptr; baseSel = v.base; idxSel = v.idx;
    disp = v.disp; dispWide = v.wide; ovrEn = v.ovr; ovrSeg = v.ovrSeg;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkResult(input vecT v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    check({tag, " valid (R2)"}, 64'(outValid), 64'd1);
    check({tag, " noAddr"}, 64'(outNoAddr), 64'(v.noAddr));
    check({tag, " offset"}, 64'(outOffset), 64'(v.ofs));
    check({tag, " phys (R3)"}, 64'(outPhys), 64'(v.phys));
    check({tag, " seg"}, 64'(outSeg), 64'(v.seg));
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", 64'(outValid), 64'd0);
        check("R1 phys", 64'(outPhys), 64'd0);
        check("R1 offset", 64'(outOffset), 64'd0);
        rstN = 1'b1;
        @(negedge clk);
        check("R1 after release", 64'({outValid, outNoAddr, outSeg}), 64'd0);

        for (int i = 0; i < NV; i++) begin
          issue(VECS[i]);
          checkResult(VECS[i]);
        end

        // R2: without a request, valid drops and the result holds
        @(negedge clk);
        mode = 3'd3; ptrSel = 2'd0; disp = 16'h9999;
        @(negedge clk);
        check("R2 valid low", 64'(outValid), 64'd0);
        check("R2 hold offset", 64'(outOffset), 64'h1405);
        check("R2 hold phys", 64'(outPhys), 64'h21405);

        // R4: unused mode code 7
        issue('{8'd4, 3'd7, 2'd0, 1'b0, 1'b0, 16'h0101, 1'b1, 1'b1, 2'd3, 1'b1, 16'h0, 20'h0, 2'd0});
        check("R4 mode7 noAddr", 64'(outNoAddr), 64'd1);
        check("R4 mode7 phys", 64'(outPhys), 64'd0);

        // R11 and R3 wrap: BP FFF0 + DI 0020 -> 0010; SS FFFF -> FFFF0+10 wraps to 00000
        regBp = 16'hFFF0; regDi = 16'h0020; segSs = 16'hFFFF;
        issue('{8'd11, 3'd5, 2'd0, 1'b1, 1'b1, 16'h0, 1'b0, 1'b0, 2'd0, 1'b0, 16'h0010, 20'h00000, 2'd2});
        check("R11 offset wrap", 64'(outOffset), 64'h0010);
        check("R3 phys wrap", 64'(outPhys), 64'h00000);
        check("R8 seg SS", 64'(outSeg), 64'd2);

        // R10 sign-extended FF with R11 wrap: BX 0000 + (-1) -> FFFF
        regBx = 16'h0000;
        issue('{8'd10, 3'd4, 2'd0, 1'b0, 1'b0, 16'h00FF, 1'b0, 1'b0, 2'd0, 1'b0, 16'hFFFF, 20'h4FFFF, 2'd3});
        check("R10 offset", 64'(outOffset), 64'hFFFF);
        check("R10 phys", 64'(outPhys), 64'h4FFFF);

        // R2: valid lasts one cycle only
        @(negedge clk);
        check("R2 single pulse", 64'(outValid), 64'd0);

        // R1: reset in mid-run clears outputs
        rstN = 1'b0;
        @(negedge clk);
        check("R1 re-reset", 64'({outValid, outOffset, outPhys}), 64'd0);
        rstN = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule